// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular table of transmit descriptors held in a small descriptor memory. Each descriptor holds a 16-bit control/status word, a byte count and a buffer address. For every ready descriptor the engine fetches the bytes of its buffer, one at a time, from a byte-wide buffer memory and presents them on a byte-wide transmit stream. One frame can span several descriptors. The last descriptor of a frame is the one whose LAST bit is set. After each descriptor has been consumed, the engine writes its status word back and clears the ready bit, which hands the descriptor back to software. The status word of the last descriptor also carries the frame's error flags.

The engine applies three frame-level rules. First, a frame is cut at a programmable maximum length unless huge frames are allowed. Second, a frame whose buffer memory fails to deliver a byte on time is aborted. Third, a padded frame whose first buffer is misaligned is skipped without sending any of it. In each of these cases the engine still consumes the frame's remaining descriptors, up to and including the last one, without sending anything. The control word layout is: bit 15 READY, bit 14 WRAP, bit 13 LAST, bit 12 PAD, bit 11 OFLD, bit 10 HUGE, bit 9 UN, bit 8 TR, bit 7 AE. The descriptor word is {control[15:0], length[15:0], pointer[15:0]}.

The controller has five states:
- IDLE: while `en` is high, it issues a descriptor read at the current ring index.
- FETCH: it examines the returned descriptor.
  - IDLE→FETCH happens when `en` is high.
  - FETCH→IDLE happens when the descriptor is not ready.
  - FETCH→WBACK happens when the frame is being discarded, or when the first descriptor is misaligned.
  - FETCH→REQ happens otherwise.
- REQ: it issues one buffer read. REQ→BYTE is unconditional.
- BYTE: it takes the returned byte.
  - BYTE→REQ happens while bytes remain in the descriptor.
  - BYTE→WBACK happens at the descriptor's end, at the length cut, or on an underrun.
- WBACK: it writes the status word and advances the ring. WBACK→IDLE is unconditional.

Top module: `txdesc_engine`

## Requirements
- R1: A descriptor is ready only when READY (bit 15) is set and its length is nonzero. Otherwise the engine re-polls the same index, sending no byte and writing back nothing.
- R2: A ready descriptor with length N and pointer P yields the bytes at addresses P..P+N-1, in order, one `tx_valid` byte each. `tx_last` marks the final byte of the descriptor that has LAST (bit 13) set.
- R3: A frame spread over several descriptors is sent as the concatenation of their buffers, with `tx_last` only on the final byte.
- R4: Every consumed descriptor gets a status write at its own index. The write clears READY, keeps the other control bits, and leaves the length untouched (only the status word is written). UN, TR and AE appear only in the last descriptor of a frame.
- R5: The ring index starts at 0, advances by one after each writeback, and returns to 0 after a descriptor with WRAP (bit 14) set.
- R6: When neither HUGE (bit 10) of the first descriptor nor `huge_en` is set, at most `max_len` bytes are sent. Byte number `max_len` carries `tx_last`. TR (bit 8) is set whenever the frame length is at least `max_len`. Any bytes past the limit are dropped, but their descriptors are still consumed.
- R7: With HUGE set in the first descriptor, or with `huge_en` high, the whole frame is sent and TR stays clear.
- R8: If, in the cycle after a buffer read, `buf_vld` is low or `buf_err` is high, no byte is sent and `tx_abort` pulses for one cycle. The rest of the frame is discarded, and UN (bit 9) is set in its last descriptor.
- R9: If PAD (bit 12) is set in the first descriptor and its pointer's low three bits are nonzero, nothing of the frame is sent and AE (bit 7) is set in the last descriptor. PAD in later descriptors has no effect.
- R10: `tx_offload` follows OFLD (bit 11) of the frame's first descriptor on every byte. OFLD in later descriptors has no effect.
- R11: After reset no byte, buffer read or status write is issued, and the first descriptor read targets index 0.
- R12: Every `tx_valid` byte follows a `buf_rd` one cycle earlier, and two buffer reads are never issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Allows descriptor polling |
| max_len | input | LEN_W | Maximum frame length in bytes |
| huge_en | input | 1 | Global allowance for frames past `max_len` |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_addr | output | IDX_W | Ring index to read |
| desc_rd_data | input | 16+LEN_W+AW | Descriptor word, valid one cycle after the strobe |
| desc_wr_en | output | 1 | Status writeback strobe |
| desc_wr_addr | output | IDX_W | Ring index written |
| desc_wr_status | output | 16 | New control/status word |
| buf_rd | output | 1 | Buffer byte read strobe |
| buf_addr | output | AW | Buffer byte address |
| buf_vld | input | 1 | Byte available, one cycle after `buf_rd` |
| buf_err | input | 1 | Bus error on the read |
| buf_data | input | 8 | Returned byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_abort | output | 1 | Frame aborted by underrun |
| tx_offload | output | 1 | Frame's offload request |

## Verification
- Descriptor data is returned one cycle after `desc_rd_en`, and a byte appears on `tx_valid` in the cycle after its `buf_rd`.
- The status write of a descriptor comes one cycle after its final byte. For a skipped descriptor, it comes one cycle after the fetch.
- The bench's memory models answer on those exact edges. The bench records the stream and the status writes on the falling edge. It waits for the expected number of writebacks before it compares them with a frame model computed from the requirements.
- The length limit is swept over frame lengths below, at and above `max_len`, for both single-descriptor and two-descriptor frames.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    localparam int CTRL_W = 16;
    localparam int B_RDY  = 15;
    localparam int B_WRAP = 14;
    localparam int B_LAST = 13;
    localparam int B_PAD  = 12;
    localparam int B_OFLD = 11;
    localparam int B_HUGE = 10;
    localparam int B_UN   = 9;
    localparam int B_TR   = 8;
    localparam int B_AE   = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_REQ, S_BYTE, S_WBACK
    } eng_state_t;
endpackage

// File: rtl/txdesc_ring_ptr.sv
module txdesc_ring_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (adv)  idx <= wrap ? '0 : idx + 1'b1;
    end

    // R5
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap) |=> (idx == '0));
endmodule

// File: rtl/txdesc_frame_ctl.sv
module txdesc_frame_ctl #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] max_len,
    input  logic             huge_en,
    input  logic             accept_first,
    input  logic             misalign,
    input  logic             ofld_in,
    input  logic             hfe_in,
    input  logic             byte_fire,
    input  logic             underrun,
    input  logic             frame_done,
    output logic             first,
    output logic             discard,
    output logic             flag_un,
    output logic             flag_tr,
    output logic             flag_ae,
    output logic             ofld,
    output logic             cut_now
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt;
    logic             hfe_q;
    logic             limit_on;

    assign limit_on = !(huge_en || hfe_q);
    assign cut_now  = limit_on && ((cnt + ONE) == max_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first <= 1'b1; discard <= 1'b0; flag_un <= 1'b0; flag_tr <= 1'b0;
            flag_ae <= 1'b0; ofld <= 1'b0; hfe_q <= 1'b0; cnt <= '0;
        end else if (frame_done) begin
            first <= 1'b1; discard <= 1'b0; flag_un <= 1'b0; flag_tr <= 1'b0;
            flag_ae <= 1'b0; ofld <= 1'b0;
        end else begin
            if (accept_first) begin
                first <= 1'b0;
                ofld  <= ofld_in;
                hfe_q <= hfe_in;
                cnt   <= '0;
                if (misalign) begin
                    flag_ae <= 1'b1;
                    discard <= 1'b1;
                end
            end
            if (byte_fire) begin
                cnt <= cnt + ONE;
                if (cut_now) begin
                    flag_tr <= 1'b1;
                    discard <= 1'b1;
                end
            end
            if (underrun) begin
                flag_un <= 1'b1;
                discard <= 1'b1;
            end
        end
    end

    // R6
    cnt_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && limit_on && max_len != '0) |-> (cnt < max_len));
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txdesc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int AW    = 16,
    parameter int LEN_W = 16,
    localparam int DW   = CTRL_W + LEN_W + AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              huge_en,
    output logic              desc_rd_en,
    output logic [IDX_W-1:0]  desc_rd_addr,
    input  logic [DW-1:0]     desc_rd_data,
    output logic              desc_wr_en,
    output logic [IDX_W-1:0]  desc_wr_addr,
    output logic [CTRL_W-1:0] desc_wr_status,
    output logic              buf_rd,
    output logic [AW-1:0]     buf_addr,
    input  logic              buf_vld,
    input  logic              buf_err,
    input  logic [7:0]        buf_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_abort,
    output logic              tx_offload
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    eng_state_t state_q, state_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [LEN_W-1:0]  len_q, off_q;
    logic [AW-1:0]     ptr_q;
    logic [IDX_W-1:0]  idx;

    logic [CTRL_W-1:0] d_ctrl;
    logic [LEN_W-1:0]  d_len;
    logic [AW-1:0]     d_ptr;
    logic d_ready, d_misalign, accept, skip, underrun, desc_end, byte_fire;
    logic first, discard, flag_un, flag_tr, flag_ae, ofld, cut_now;

    assign d_ctrl     = desc_rd_data[DW-1 -: CTRL_W];
    assign d_len      = desc_rd_data[AW +: LEN_W];
    assign d_ptr      = desc_rd_data[AW-1:0];
    assign d_ready    = d_ctrl[B_RDY] && (d_len != '0);
    assign d_misalign = d_ctrl[B_PAD] && (d_ptr[2:0] != 3'b000);
    assign accept     = (state_q == S_FETCH) && d_ready;
    assign skip       = discard || (first && d_misalign);
    assign underrun   = (state_q == S_BYTE) && (!buf_vld || buf_err);
    assign byte_fire  = (state_q == S_BYTE) && !underrun;
    assign desc_end   = (off_q + ONE) == len_q;

    txdesc_ring_ptr #(.IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .adv(state_q == S_WBACK), .wrap(ctrl_q[B_WRAP]), .idx(idx)
    );

    txdesc_frame_ctl #(.LEN_W(LEN_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .max_len(max_len), .huge_en(huge_en),
        .accept_first(accept && first), .misalign(d_misalign),
        .ofld_in(d_ctrl[B_OFLD]), .hfe_in(d_ctrl[B_HUGE]),
        .byte_fire(byte_fire), .underrun(underrun),
        .frame_done((state_q == S_WBACK) && ctrl_q[B_LAST]),
        .first(first), .discard(discard), .flag_un(flag_un), .flag_tr(flag_tr),
        .flag_ae(flag_ae), .ofld(ofld), .cut_now(cut_now)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (en) state_d = S_FETCH;
            S_FETCH: if (!d_ready)  state_d = S_IDLE;
                     else if (skip) state_d = S_WBACK;
                     else           state_d = S_REQ;
            S_REQ:   state_d = S_BYTE;
            S_BYTE:  if (underrun || cut_now || desc_end) state_d = S_WBACK;
                     else                                 state_d = S_REQ;
            S_WBACK: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // descriptor datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; len_q <= '0; ptr_q <= '0; off_q <= '0;
        end else if (accept) begin
            ctrl_q <= d_ctrl; len_q <= d_len; ptr_q <= d_ptr; off_q <= '0;
        end else if (byte_fire) begin
            off_q <= off_q + ONE;
        end
    end

    // outputs
    always_comb begin
        desc_rd_en     = (state_q == S_IDLE) && en;
        desc_rd_addr   = idx;
        desc_wr_en     = (state_q == S_WBACK);
        desc_wr_addr   = idx;
        desc_wr_status = ctrl_q;
        desc_wr_status[B_RDY] = 1'b0;
        desc_wr_status[B_UN]  = ctrl_q[B_LAST] && flag_un;
        desc_wr_status[B_TR]  = ctrl_q[B_LAST] && flag_tr;
        desc_wr_status[B_AE]  = ctrl_q[B_LAST] && flag_ae;
        buf_rd         = (state_q == S_REQ);
        buf_addr       = ptr_q + AW'(off_q);
        tx_valid       = byte_fire;
        tx_data        = buf_data;
        tx_last        = byte_fire && (cut_now || (desc_end && ctrl_q[B_LAST]));
        tx_abort       = underrun;
        tx_offload     = byte_fire && ofld;
    end

    // R12
    byte_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(buf_rd));
    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !buf_rd);
    // R8
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !tx_valid);
    // R4
    wb_after_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |=> !desc_wr_en);
endmodule

// File: tb/txdesc_engine_tb.sv
module txdesc_engine_tb;
    localparam int IDX_W = 3, AW = 16, LEN_W = 16, DW = 16 + LEN_W + AW;
    localparam int RING = 6;
    localparam logic [15:0] RDY = 16'h8000, WRAP = 16'h4000, LAST = 16'h2000,
        PAD = 16'h1000, OFLD = 16'h0800, HUGE = 16'h0400,
        UN = 16'h0200, TR = 16'h0100, AE = 16'h0080;

    logic clk = 0, rst_n = 0, en = 0, huge_en = 0;
    logic [LEN_W-1:0] max_len = 16'd1000;
    logic desc_rd_en, desc_wr_en, buf_rd, buf_vld = 0, buf_err = 0;
    logic tx_valid, tx_last, tx_abort, tx_offload;
    logic [IDX_W-1:0] desc_rd_addr, desc_wr_addr;
    logic [DW-1:0] desc_rd_data = '0;
    logic [15:0] desc_wr_status;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_data = 0, tx_data;

    always #10 clk = ~clk;

    txdesc_engine #(.IDX_W(IDX_W), .AW(AW), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .max_len(max_len), .huge_en(huge_en),
        .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
        .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr), .desc_wr_status(desc_wr_status),
        .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_vld(buf_vld), .buf_err(buf_err),
        .buf_data(buf_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_abort(tx_abort), .tx_offload(tx_offload));

    logic [DW-1:0] dmem [8];
    logic [AW-1:0] bad_addr = 16'hFFFF, err_addr = 16'hFFFF;
    int checks = 0, errors = 0, cyc = 0, ng = 0, n_abort = 0, n_wb = 0, pos = 0;
    logic [7:0] got_d [64];
    logic got_l [64], got_o [64];
    logic [15:0] fr_ctl [4];
    logic [15:0] fr_len [4], fr_ptr [4];
    int fr_n;

    // memory models
    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
        buf_vld  <= buf_rd && (buf_addr != bad_addr);
        buf_err  <= buf_rd && (buf_addr == err_addr);
        buf_data <= buf_addr[7:0] ^ 8'h3C;
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid && ng < 64) begin
            got_d[ng] = tx_data; got_l[ng] = tx_last; got_o[ng] = tx_offload; ng++;
        end
        if (rst_n && tx_abort) n_abort++;
        if (rst_n && desc_wr_en) begin
            dmem[desc_wr_addr][DW-1 -: 16] = desc_wr_status; n_wb++;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic go(input string rq);
        int slot [4];
        logic [15:0] ectl [4];
        logic [7:0] ed [64];
        logic el [64];
        int wb0, t, exp_n, cnt;
        logic un, tr, ae, stop, limit;
        logic [AW-1:0] a;
        @(negedge clk);
        ng = 0; n_abort = 0; wb0 = n_wb;
        for (int i = fr_n - 1; i >= 0; i--) begin
            slot[i] = (pos + i) % RING;
            ectl[i] = fr_ctl[i] | RDY | ((slot[i] == RING - 1) ? WRAP : 16'h0)
                      | ((i == fr_n - 1) ? LAST : 16'h0);
            dmem[slot[i]] = {ectl[i], fr_len[i], fr_ptr[i]};
        end
        t = 0;
        while (n_wb < wb0 + fr_n && t < 3000) begin @(negedge clk); t++; end
        chk(n_wb == wb0 + fr_n, {rq, " R5 writeback count"}, n_wb - wb0, fr_n);
        // expected frame
        limit = !(huge_en || fr_ctl[0][10]);
        un = 0; tr = 0; ae = 0; stop = 0; exp_n = 0; cnt = 0;
        if (fr_ctl[0][12] && fr_ptr[0][2:0] != 3'b0) begin ae = 1; stop = 1; end
        for (int d = 0; d < fr_n; d++)
            for (int b = 0; b < int'(fr_len[d]); b++)
                if (!stop) begin
                    a = fr_ptr[d] + AW'(b);
                    if (a == bad_addr || a == err_addr) begin un = 1; stop = 1; end
                    else begin
                        ed[exp_n] = a[7:0] ^ 8'h3C;
                        el[exp_n] = (d == fr_n - 1) && (b == int'(fr_len[d]) - 1);
                        cnt++;
                        if (limit && cnt == int'(max_len)) begin tr = 1; el[exp_n] = 1; stop = 1; end
                        exp_n++;
                    end
                end
        chk(ng == exp_n, {rq, " R2 byte count"}, ng, exp_n);
        for (int k = 0; k < exp_n && k < ng; k++) begin
            chk(got_d[k] == ed[k], {rq, " R2 R3 data"}, got_d[k], ed[k]);
            chk(got_l[k] == el[k], {rq, " R2 R6 last"}, got_l[k], el[k]);
            chk(got_o[k] == fr_ctl[0][11], {rq, " R10 offload"}, got_o[k], fr_ctl[0][11]);
        end
        chk(n_abort == int'(un), {rq, " R8 abort"}, n_abort, un);
        for (int i = 0; i < fr_n; i++) begin
            logic [15:0] e;
            e = ectl[i] & ~RDY;
            if (i == fr_n - 1) e = e | (un ? UN : 16'h0) | (tr ? TR : 16'h0) | (ae ? AE : 16'h0);
            chk(dmem[slot[i]][DW-1 -: 16] == e, {rq, " R4 status"}, dmem[slot[i]][DW-1 -: 16], e);
            chk(dmem[slot[i]][AW +: LEN_W] == fr_len[i], {rq, " R4 length kept"},
                dmem[slot[i]][AW +: LEN_W], fr_len[i]);
        end
        pos = (pos + fr_n) % RING;
    endtask

    task automatic one(input logic [15:0] c, input logic [15:0] l, input logic [15:0] p);
        fr_n = 1; fr_ctl[0] = c; fr_len[0] = l; fr_ptr[0] = p;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_valid && !buf_rd && !desc_wr_en, "R11 idle after reset", tx_valid, 0);
        chk(desc_rd_addr == 0, "R11 index zero", desc_rd_addr, 0);
        en = 1;

        // R1 not ready: zero length, then ready bit clear
        dmem[0] = {RDY | LAST, 16'd0, 16'h0010};
        repeat (30) @(negedge clk);
        chk(n_wb == 0 && ng == 0, "R1 zero length stalls", n_wb + ng, 0);
        dmem[0] = {LAST, 16'd3, 16'h0010};
        repeat (30) @(negedge clk);
        chk(n_wb == 0 && ng == 0, "R1 ready clear stalls", n_wb + ng, 0);

        one(16'h0, 16'd5, 16'h0010); go("R2 single");
        fr_n = 3;
        fr_ctl[0] = 16'h0; fr_len[0] = 3; fr_ptr[0] = 16'h0020;
        fr_ctl[1] = PAD | OFLD; fr_len[1] = 1; fr_ptr[1] = 16'h0047;
        fr_ctl[2] = 16'h0; fr_len[2] = 4; fr_ptr[2] = 16'h0063;
        go("R3 R9 R10 multi");

        max_len = 16'd6;
        for (int L = 1; L <= 9; L++) begin
            one(16'h0, 16'(L), 16'h0080); go("R6 sweep single");
            if (L >= 2) begin
                fr_n = 2;
                fr_ctl[0] = 16'h0; fr_len[0] = 16'(L / 2); fr_ptr[0] = 16'h00A0;
                fr_ctl[1] = 16'h0; fr_len[1] = 16'(L - L / 2); fr_ptr[1] = 16'h00C5;
                go("R6 sweep split");
            end
        end
        one(HUGE, 16'd9, 16'h0040); go("R7 descriptor huge");
        fr_n = 2;
        fr_ctl[0] = 16'h0; fr_len[0] = 4; fr_ptr[0] = 16'h0050;
        fr_ctl[1] = HUGE; fr_len[1] = 5; fr_ptr[1] = 16'h0060;
        go("R6 huge in later descriptor");
        huge_en = 1; one(16'h0, 16'd9, 16'h0070); go("R7 global huge");
        huge_en = 0; max_len = 16'd1000;

        fr_n = 2;
        fr_ctl[0] = PAD; fr_len[0] = 3; fr_ptr[0] = 16'h0023;
        fr_ctl[1] = 16'h0; fr_len[1] = 2; fr_ptr[1] = 16'h0030;
        go("R9 misaligned");
        one(PAD, 16'd4, 16'h0028); go("R9 aligned");

        bad_addr = 16'h0092;
        fr_n = 2;
        fr_ctl[0] = 16'h0; fr_len[0] = 4; fr_ptr[0] = 16'h0090;
        fr_ctl[1] = 16'h0; fr_len[1] = 3; fr_ptr[1] = 16'h00B0;
        go("R8 late data");
        bad_addr = 16'hFFFF; err_addr = 16'h00B1;
        go("R8 bus error");
        err_addr = 16'hFFFF;

        one(OFLD, 16'd4, 16'h00D0); go("R10 offload");
        one(16'h0, 16'd2, 16'h00E0); go("R5 after wrap");
        summary();
    end
endmodule